// File: doc/BRIEF.md
# Song Sequencer Control

This block steps through a song held in an external table and feeds it, one note at a time, to a separate multi-note tone player. A controller selects one of up to 32 songs with a 5-bit number and pulses a start input. The sequencer then reads table words in order, starting at an address derived from the song number. For each word that is an ordinary note, it issues a one-cycle load to the tone player and waits for that player to report the note finished. A word flagged as a terminator ends playback.

The control is a Mealy machine with four states: idle, fetch, load and wait. In the fetch state, the memory request and its address are driven combinationally, and the response word is consumed in that same cycle. The choice between loading a note and returning to idle is made from that response. In the wait state, the move back to fetch, together with the address increment, is made from the player's done input. One 16-bit duration applies to every note and is handed to the player with each load. A value of 0x2000 gives a short note that can still be heard.

Top module: `song_seq`

## Requirements
- R1: While reset is active, and after it is released with no start, `idle_o` is 1 and `mem_req_o`, `play_load_o` and `note_sel_o` are all 0.
- R2: A start pulse sampled while idle produces a memory request in the next cycle, at address `song_i << 8`. The song number occupies address bits [12:8] and bits [7:0] are zero.
- R3: `mem_req_o` is high for exactly one cycle per table word and never while `idle_o` is high. The response word is used in the cycle the request is high.
- R4: A response with bit 31 clear makes `play_load_o` high for exactly one cycle, in the cycle after the request. In that cycle `play_note_o` and `note_sel_o` equal response bits [2:0]. Bits [30:3] have no effect.
- R5: Whenever `play_load_o` is high, `play_dur_o` equals `note_len_i`.
- R6: After a load, the block issues no request until `play_done_i` has been seen high in a cycle after the load. In the cycle after that, it requests the address one above the previous one. With a player that counts a duration D down to zero, this gives D+1 cycles between the load and the next request.
- R7: A response with bit 31 set returns the block to idle in the next cycle, with no load. An empty song therefore ends after a single request.
- R8: Start pulses and changes of `song_i` while a song is playing have no effect on the address sequence or on the notes.
- R9: `idle_o` is 0 from the first request of a song until the terminator has been read. A new start after a song ends begins that song normally.
- R10: `note_sel_o` changes only on a note load. After a song ends, it keeps the last note played.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset; asserts asynchronously and is released synchronously |
| start_i | input | 1 | Start pulse; acted on only while idle |
| song_i | input | 5 | Song number |
| note_len_i | input | 16 | Duration applied to every note |
| mem_req_o | output | 1 | Table read request valid |
| mem_addr_o | output | 16 | Table read address |
| mem_rdata_i | input | 32 | Table word, combinational response to the request |
| play_load_o | output | 1 | One-cycle load strobe to the tone player |
| play_note_o | output | 3 | Note number handed to the tone player |
| play_dur_o | output | 16 | Duration handed to the tone player |
| play_done_i | input | 1 | Tone player has finished its current note |
| note_sel_o | output | 3 | Note currently playing (last note loaded) |
| idle_o | output | 1 | High when no song is playing |

## Verification
The properties assume that `mem_rdata_i` settles within the cycle in which the request is high. They also assume that `play_done_i` drops no later than the cycle after a load, so that a stale done from the previous note is never read as completion. The bench meets both conditions: its table is a pure function of the address, and its player model reloads its counter on the load edge. The player model is also run with a zero duration, in which done never drops, to exercise the earliest possible advance.

// File: rtl/song_seq_pkg.sv
package song_seq_pkg;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_FETCH = 2'd1,
    ST_LOAD  = 2'd2,
    ST_WAIT  = 2'd3
  } seq_state_e;

  typedef struct packed {
    logic mem_req;
    logic base_ld;
    logic addr_inc;
    logic note_cap;
    logic play_load;
  } seq_ctl_t;

endpackage

// File: rtl/song_seq_rst_sync.sv
module song_seq_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_q_n
);
  logic [STAGES-1:0] chain_q;

  generate
    if (STAGES == 1) begin : g_one
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain_q <= '0;
        else        chain_q <= 1'b1;
      end
    end else begin : g_many
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain_q <= '0;
        else        chain_q <= {chain_q[STAGES-2:0], 1'b1};
      end
    end
  endgenerate

  assign rst_q_n = chain_q[STAGES-1];
endmodule

// File: rtl/song_seq_ctrl.sv
module song_seq_ctrl
  import song_seq_pkg::*;
(
  input  logic     clk,
  input  logic     rst_n,
  input  logic     start_i,
  input  logic     end_flag_i,
  input  logic     play_done_i,
  output seq_ctl_t ctl_o,
  output logic     idle_o
);
  seq_state_e state_q, state_d;

  // Next state and Mealy outputs
  always_comb begin
    state_d = state_q;
    ctl_o   = '0;
    unique case (state_q)
      ST_IDLE: begin
        if (start_i) begin
          ctl_o.base_ld = 1'b1;
          state_d       = ST_FETCH;
        end
      end
      ST_FETCH: begin
        ctl_o.mem_req = 1'b1;
        if (end_flag_i) begin
          state_d = ST_IDLE;
        end else begin
          ctl_o.note_cap = 1'b1;
          state_d        = ST_LOAD;
        end
      end
      ST_LOAD: begin
        ctl_o.play_load = 1'b1;
        state_d         = ST_WAIT;
      end
      ST_WAIT: begin
        if (play_done_i) begin
          ctl_o.addr_inc = 1'b1;
          state_d        = ST_FETCH;
        end
      end
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state_q <= ST_IDLE;
    else        state_q <= state_d;
  end

  assign idle_o = (state_q == ST_IDLE);
endmodule

// File: rtl/song_seq_addr.sv
module song_seq_addr #(
  parameter int SONG_W     = 5,
  parameter int ADDR_W     = 16,
  parameter int BASE_SHIFT = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              base_ld_i,
  input  logic              inc_i,
  input  logic [SONG_W-1:0] song_i,
  output logic [ADDR_W-1:0] addr_o
);
  logic [ADDR_W-1:0] addr_q, base_w;

  assign base_w = ADDR_W'(song_i) << BASE_SHIFT;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      addr_q <= '0;
    end else if (base_ld_i) begin
      addr_q <= base_w;
    end else if (inc_i) begin
      addr_q <= addr_q + ADDR_W'(1);
    end
  end

  assign addr_o = addr_q;
endmodule

// File: rtl/song_seq_note.sv
module song_seq_note #(
  parameter int NOTE_W = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cap_en_i,
  input  logic [NOTE_W-1:0] note_i,
  output logic [NOTE_W-1:0] note_o
);
  logic [NOTE_W-1:0] note_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        note_q <= '0;
    else if (cap_en_i) note_q <= note_i;
  end

  assign note_o = note_q;
endmodule

// File: rtl/song_seq.sv
module song_seq
  import song_seq_pkg::*;
#(
  parameter int SONG_W      = 5,
  parameter int ADDR_W      = 16,
  parameter int DATA_W      = 32,
  parameter int NOTE_W      = 3,
  parameter int DUR_W       = 16,
  parameter int BASE_SHIFT  = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start_i,
  input  logic [SONG_W-1:0] song_i,
  input  logic [DUR_W-1:0]  note_len_i,
  output logic              mem_req_o,
  output logic [ADDR_W-1:0] mem_addr_o,
  input  logic [DATA_W-1:0] mem_rdata_i,
  output logic              play_load_o,
  output logic [NOTE_W-1:0] play_note_o,
  output logic [DUR_W-1:0]  play_dur_o,
  input  logic              play_done_i,
  output logic [NOTE_W-1:0] note_sel_o,
  output logic              idle_o
);
  localparam int END_BIT = DATA_W - 1;

  logic     rst_q_n;
  seq_ctl_t ctl;
  logic     unused_payload;

  assign unused_payload = ^mem_rdata_i[END_BIT-1:NOTE_W];

  song_seq_rst_sync #(.STAGES(SYNC_STAGES)) u_rst (
    .clk     (clk),
    .rst_n   (rst_n),
    .rst_q_n (rst_q_n)
  );

  song_seq_ctrl u_ctrl (
    .clk         (clk),
    .rst_n       (rst_q_n),
    .start_i     (start_i),
    .end_flag_i  (mem_rdata_i[END_BIT]),
    .play_done_i (play_done_i),
    .ctl_o       (ctl),
    .idle_o      (idle_o)
  );

  song_seq_addr #(
    .SONG_W     (SONG_W),
    .ADDR_W     (ADDR_W),
    .BASE_SHIFT (BASE_SHIFT)
  ) u_addr (
    .clk       (clk),
    .rst_n     (rst_q_n),
    .base_ld_i (ctl.base_ld),
    .inc_i     (ctl.addr_inc),
    .song_i    (song_i),
    .addr_o    (mem_addr_o)
  );

  song_seq_note #(.NOTE_W(NOTE_W)) u_note (
    .clk      (clk),
    .rst_n    (rst_q_n),
    .cap_en_i (ctl.note_cap),
    .note_i   (mem_rdata_i[NOTE_W-1:0]),
    .note_o   (note_sel_o)
  );

  assign mem_req_o   = ctl.mem_req;
  assign play_load_o = ctl.play_load;
  assign play_note_o = note_sel_o;
  assign play_dur_o  = note_len_i;
endmodule

// File: rtl/song_seq_chk.sv
module song_seq_chk #(
  parameter int SONG_W     = 5,
  parameter int ADDR_W     = 16,
  parameter int DATA_W     = 32,
  parameter int NOTE_W     = 3,
  parameter int BASE_SHIFT = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              start_i,
  input logic [SONG_W-1:0] song_i,
  input logic              mem_req_o,
  input logic [ADDR_W-1:0] mem_addr_o,
  input logic [DATA_W-1:0] mem_rdata_i,
  input logic              play_load_o,
  input logic              play_done_i,
  input logic [NOTE_W-1:0] note_sel_o,
  input logic              idle_o
);
  // R2
  start_base_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (idle_o && start_i) |=> (mem_req_o && mem_addr_o == (ADDR_W'($past(song_i)) << BASE_SHIFT)));

  // R3
  req_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req_o |-> !idle_o);

  // R4
  load_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req_o && !mem_rdata_i[DATA_W-1]) |=>
      (play_load_o && note_sel_o == $past(mem_rdata_i[NOTE_W-1:0])));

  // R4
  load_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    play_load_o |=> (!play_load_o && !mem_req_o));

  // R7
  end_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req_o && mem_rdata_i[DATA_W-1]) |=> (idle_o && !play_load_o));

  // R6
  wait_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!idle_o && !mem_req_o && !play_done_i) |=> (!mem_req_o && $stable(mem_addr_o)));

  // R6
  advance_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!idle_o && !mem_req_o && !play_load_o && play_done_i) |=>
      (mem_req_o && mem_addr_o == $past(mem_addr_o) + ADDR_W'(1)));

  // R8
  busy_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!idle_o && !mem_req_o && start_i && !play_done_i) |=> $stable(mem_addr_o));

  // R10
  note_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !mem_req_o |=> $stable(note_sel_o));
endmodule

bind song_seq song_seq_chk #(
  .SONG_W     (SONG_W),
  .ADDR_W     (ADDR_W),
  .DATA_W     (DATA_W),
  .NOTE_W     (NOTE_W),
  .BASE_SHIFT (BASE_SHIFT)
) u_chk (
  .clk         (clk),
  .rst_n       (rst_q_n),
  .start_i     (start_i),
  .song_i      (song_i),
  .mem_req_o   (mem_req_o),
  .mem_addr_o  (mem_addr_o),
  .mem_rdata_i (mem_rdata_i),
  .play_load_o (play_load_o),
  .play_done_i (play_done_i),
  .note_sel_o  (note_sel_o),
  .idle_o      (idle_o)
);

// File: tb/sim_song_seq.sv
module sim_song_seq;
  logic        clk;
  logic        rst_n;
  logic        start_i;
  logic [4:0]  song_i;
  logic [15:0] note_len_i;
  logic        mem_req_o;
  logic [15:0] mem_addr_o;
  logic [31:0] mem_rdata_i;
  logic        play_load_o;
  logic [2:0]  play_note_o;
  logic [15:0] play_dur_o;
  logic        play_done_i;
  logic [2:0]  note_sel_o;
  logic        idle_o;

  int errors = 0;
  int checks = 0;
  int cycles = 0;
  logic [2:0]  last_note = 3'd0;
  logic [15:0] player_cnt;

  song_seq u0 (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .song_i(song_i),
    .note_len_i(note_len_i), .mem_req_o(mem_req_o), .mem_addr_o(mem_addr_o),
    .mem_rdata_i(mem_rdata_i), .play_load_o(play_load_o), .play_note_o(play_note_o),
    .play_dur_o(play_dur_o), .play_done_i(play_done_i), .note_sel_o(note_sel_o),
    .idle_o(idle_o)
  );

  initial clk = 1'b0;
  always #2 clk = ~clk;

  // Song table: song s holds s%5 notes, then a terminator
  function automatic logic [31:0] word_at(input logic [15:0] a);
    int s;
    int i;
    logic [31:0] w;
    s = int'(a[12:8]);
    i = int'(a[7:0]);
    if (a[15:13] != 3'd0 || i >= (s % 5)) return 32'hC000_0005;
    w = 32'h2A5A_5A50;
    w[10:3] = a[7:0];
    w[2:0] = 3'((s * 3 + i) % 8);
    w[31] = 1'b0;
    return w;
  endfunction

  always_comb mem_rdata_i = word_at(mem_addr_o);

  // Tone player model: counts the duration down to zero
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)               player_cnt <= 16'd0;
    else if (play_load_o)     player_cnt <= play_dur_o;
    else if (player_cnt != 0) player_cnt <= player_cnt - 16'd1;
  end
  assign play_done_i = (player_cnt == 16'd0);

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic do_reset();
    rst_n = 1'b0;
    start_i = 1'b0;
    song_i = 5'd0;
    note_len_i = 16'd0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
  endtask

  task automatic test_reset_state();
    do_reset();
    chk(idle_o === 1'b1, "R1", 32'(idle_o), 1);
    chk(mem_req_o === 1'b0, "R1", 32'(mem_req_o), 0);
    chk(play_load_o === 1'b0, "R1", 32'(play_load_o), 0);
    chk(note_sel_o === 3'd0, "R1", 32'(note_sel_o), 0);
  endtask

  task automatic play_song(input int s, input int dur, input bit poke);
    logic [15:0] base;
    logic [31:0] w;
    int n;
    base = 16'(s << 8);
    @(negedge clk);
    song_i = 5'(s);
    note_len_i = 16'(dur);
    start_i = 1'b1;
    @(negedge clk);
    start_i = 1'b0;
    song_i = 5'(s + 7);
    for (int i = 0; i < 16; i++) begin
      chk(mem_req_o === 1'b1, "R3", 32'(mem_req_o), 1);
      chk(mem_addr_o === base + 16'(i), (i == 0) ? "R2" : (poke ? "R8" : "R6"),
          32'(mem_addr_o), 32'(base + 16'(i)));
      w = word_at(base + 16'(i));
      @(negedge clk);
      if (w[31]) begin
        chk(idle_o === 1'b1, "R7", 32'(idle_o), 1);
        chk(play_load_o === 1'b0, "R7", 32'(play_load_o), 0);
        chk(note_sel_o === last_note, "R10", 32'(note_sel_o), 32'(last_note));
        break;
      end
      chk(play_load_o === 1'b1, "R4", 32'(play_load_o), 1);
      chk(play_note_o === w[2:0], "R4", 32'(play_note_o), 32'(w[2:0]));
      chk(note_sel_o === w[2:0], "R4", 32'(note_sel_o), 32'(w[2:0]));
      chk(play_dur_o === 16'(dur), "R5", 32'(play_dur_o), 32'(dur));
      chk(idle_o === 1'b0, "R9", 32'(idle_o), 0);
      last_note = w[2:0];
      n = 0;
      @(negedge clk);
      while (!mem_req_o && n < dur + 10) begin
        if (poke && n == 0) begin
          start_i = 1'b1;
          song_i = 5'(s ^ 31);
        end else begin
          start_i = 1'b0;
        end
        if (play_load_o) chk(1'b0, "R4", 1, 0);
        n++;
        @(negedge clk);
      end
      start_i = 1'b0;
      chk(n == dur + 1, "R6", 32'(n), 32'(dur + 1));
      chk(note_sel_o === last_note, "R10", 32'(note_sel_o), 32'(last_note));
    end
  endtask

  task automatic test_mid_reset();
    @(negedge clk);
    song_i = 5'd3;
    note_len_i = 16'd20;
    start_i = 1'b1;
    @(negedge clk);
    start_i = 1'b0;
    repeat (6) @(negedge clk);
    rst_n = 1'b0;
    #1;
    chk(idle_o === 1'b1, "R1", 32'(idle_o), 1);
    chk(mem_req_o === 1'b0, "R1", 32'(mem_req_o), 0);
    chk(note_sel_o === 3'd0, "R1", 32'(note_sel_o), 0);
    @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    chk(idle_o === 1'b1, "R1", 32'(idle_o), 1);
    chk(mem_req_o === 1'b0, "R1", 32'(mem_req_o), 0);
    last_note = 3'd0;
  endtask

  initial begin
    test_reset_state();
    play_song(2, 5, 1'b0);
    play_song(4, 0, 1'b0);
    play_song(0, 3, 1'b0);
    play_song(3, 7, 1'b1);
    play_song(31, 2, 1'b0);
    play_song(1, 8192, 1'b0);
    test_mid_reset();
    play_song(9, 4, 1'b1);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  always @(posedge clk) begin
    cycles++;
    if (cycles > 150000) begin
      errors++;
      checks++;
      $display("FAIL watchdog actual=%0d expected=<150000", cycles);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule